// File: doc/BRIEF.md
# SPI Transmit Queue with Self-Sizing Watermark

This block is the transmit queue of an SPI controller. Bus writes to the data offset push one byte into a first-in first-out store. The serial engine takes bytes from the head through a pop port. A second bus offset holds a watermark register. The queue raises a flag whenever its occupancy is below the watermark, which tells software that there is room for more bytes.

The depth of the store is fixed when the block is built. The watermark register is exactly `log2(DEPTH)` bits wide, and any higher bits of a write are discarded. Software can therefore learn the depth at run time: it writes all ones to the watermark and reads back `DEPTH-1`. The block also reports full and empty. All flags are decoded from a registered occupancy count.

Top module: `spi_txq`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `full_o`=0), the watermark reads 1, and `over_wm_o` is 1.
- R2: A write with `wr_addr_i`=0x1C pushes `wr_data_i[7:0]`. `pop_data_o` always shows the oldest stored byte, and bytes leave in the order they were written.
- R3: A push while `full_o` is 1 is dropped. Occupancy and stored contents stay unchanged.
- R4: A pop while `empty_o` is 1 is ignored and changes no state.
- R5: A write with `wr_addr_i`=0x28 loads `wr_data_i[log2(DEPTH)-1:0]` into the watermark and discards the higher bits, so a write of 0xFFFF reads back as `DEPTH-1`. `wm_o` shows the value in the cycle after the write.
- R6: `over_wm_o` is 1 exactly when occupancy is strictly below the watermark.
- R7: `full_o` is 1 exactly at occupancy `DEPTH` and `empty_o` exactly at occupancy 0. All flags change in the cycle after the push or pop that causes the change.
- R8: A write to any offset other than 0x1C or 0x28 changes neither the contents, the flags nor the watermark.
- R9: A push and a pop in the same cycle, when the queue is neither empty nor full, leave occupancy unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write offset |
| wr_data_i | input | BUS_W | Bus write data |
| pop_i | input | 1 | Serial engine takes the head byte |
| pop_data_o | output | DATA_W | Head byte of the queue |
| wm_o | output | log2(DEPTH) | Watermark readback |
| over_wm_o | output | 1 | Occupancy below watermark |
| full_o | output | 1 | Queue full |
| empty_o | output | 1 | Queue empty |

## Verification
Every result is due one clock edge after its stimulus. A push, a pop or a watermark write takes effect at the rising edge on which it is presented, and the flags, the head byte and `wm_o` read that state combinationally. The bench drives inputs just after a falling edge and releases them shortly after the next rising edge. It samples at the following falling edge, which falls inside the first cycle in which the new value is valid. The vector table and the directed tests keep to this single-cycle latency, so each expected value is tied to exactly one stimulus.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } txq_op_e;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;

  // power-of-two depth: pointers wrap naturally
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && wr_ptr_q == PTR_W'(i)) mem_q[i] <= din_i;
    end
  end

  assign dout_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/txq_level.sv
module txq_level
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  txq_op_e          op_i,
  input  logic [PTR_W-1:0] wm_i,
  output logic             full_o,
  output logic             empty_o,
  output logic             over_wm_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      unique case (op_i)
        OP_PUSH: cnt_q <= cnt_q + 1'b1;
        OP_POP:  cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign over_wm_o = (cnt_q < {1'b0, wm_i});
endmodule

// File: rtl/txq_wm_reg.sv
module txq_wm_reg #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PTR_W-1:0] data_i,
  output logic [PTR_W-1:0] wm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wm_o <= PTR_W'(1);
    else if (wr_i) wm_o <= data_i;
  end
endmodule

// File: rtl/spi_txq.sv
module spi_txq
  import spi_txq_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_OFS = 'h1C,
  parameter int unsigned WM_OFS   = 'h28,
  localparam int unsigned PTR_W   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [PTR_W-1:0]  wm_o,
  output logic              over_wm_o,
  output logic              full_o,
  output logic              empty_o
);
  logic    push_req, wm_wr, push, pop;
  txq_op_e op;
  logic    unused_bus_bits;

  assign push_req = wr_en_i && (wr_addr_i == ADDR_W'(DATA_OFS));
  assign wm_wr    = wr_en_i && (wr_addr_i == ADDR_W'(WM_OFS));
  assign push     = push_req && !full_o;
  assign pop      = pop_i && !empty_o;
  assign op       = txq_op_e'({push, pop});
  assign unused_bus_bits = ^wr_data_i[BUS_W-1:DATA_W];

  txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (wr_data_i[DATA_W-1:0]),
    .dout_o (pop_data_o)
  );

  txq_wm_reg #(.DEPTH(DEPTH)) u_wm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wm_wr),
    .data_i (wr_data_i[PTR_W-1:0]),
    .wm_o   (wm_o)
  );

  txq_level #(.DEPTH(DEPTH)) u_level (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .wm_i      (wm_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .over_wm_o (over_wm_o)
  );
endmodule

// File: rtl/spi_txq_chk.sv
module spi_txq_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PTR_W    = 3,
  parameter int unsigned DATA_OFS = 'h1C,
  parameter int unsigned WM_OFS   = 'h28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [PTR_W-1:0]  wm_data_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] pop_data_o,
  input logic [PTR_W-1:0]  wm_o,
  input logic              over_wm_o,
  input logic              full_o,
  input logic              empty_o
);
  logic push_try, wm_try;
  assign push_try = wr_en_i && wr_addr_i == ADDR_W'(DATA_OFS);
  assign wm_try   = wr_en_i && wr_addr_i == ADDR_W'(WM_OFS);

  p_push_fills_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_try && !full_o |=> !empty_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_try && !pop_i |=> full_o && $stable(pop_data_o));
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_try |=> empty_o);
  p_wm_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wm_try |=> wm_o == $past(wm_data_i));
  p_wm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wm_try |=> $stable(wm_o));
  p_empty_below_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && wm_o != '0 |-> over_wm_o);
  p_full_above_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !over_wm_o);
  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

bind spi_txq spi_txq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
  .DATA_OFS(DATA_OFS), .WM_OFS(WM_OFS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wm_data_i  (wr_data_i[PTR_W-1:0]),
  .pop_i      (pop_i),
  .pop_data_o (pop_data_o),
  .wm_o       (wm_o),
  .over_wm_o  (over_wm_o),
  .full_o     (full_o),
  .empty_o    (empty_o)
);

// File: tb/spi_txq_tb.sv
`timescale 1ns/1ps
module spi_txq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic        pop = 0;
  logic [7:0]  pop_data;
  logic [2:0]  wm;
  logic        ovr, full, empty;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_txq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pop_i(pop), .pop_data_o(pop_data), .wm_o(wm),
    .over_wm_o(ovr), .full_o(full), .empty_o(empty)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [15:0] data;
    logic        pp;
    logic        e_ovr, e_full, e_empty;
    logic        hchk;
    logic [7:0]  head;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{1'b1, 8'h28, 16'h0004, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R5 wm=4
    '{1'b1, 8'h1C, 16'h0011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11}, // R2
    '{1'b1, 8'h1C, 16'h0022, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11},
    '{1'b1, 8'h1C, 16'h0033, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h11},
    '{1'b1, 8'h1C, 16'h0044, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h11}, // R6 4<4 false
    '{1'b1, 8'h1C, 16'h0055, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h22}, // R9
    '{1'b0, 8'h00, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33},
    '{1'b1, 8'h20, 16'h0099, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33}, // R8
    '{1'b1, 8'h28, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h33}, // R6 3<3 false
    '{1'b1, 8'h28, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33}  // R5 wm=7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic p);
    wr_en = w; wr_addr = a; wr_data = d; pop = p;
    @(posedge clk); #1;
    wr_en = 0; pop = 0;
    @(negedge clk);
  endtask

  task automatic flags(input string req, input logic eo, input logic ef, input logic ee);
    chk({req, " over_wm"}, 32'(ovr), 32'(eo));
    chk({req, " full"}, 32'(full), 32'(ef));
    chk({req, " empty"}, 32'(empty), 32'(ee));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    flags("R1", 1'b1, 1'b0, 1'b1);
    chk("R1 wm", 32'(wm), 32'd1);

    for (int i = 0; i < 10; i++) begin
      step(VEC[i].wr, VEC[i].addr, 32'(VEC[i].data), VEC[i].pp);
      flags($sformatf("R6/R7 vec%0d", i), VEC[i].e_ovr, VEC[i].e_full, VEC[i].e_empty);
      if (VEC[i].hchk) chk($sformatf("R2 vec%0d head", i), 32'(pop_data), 32'(VEC[i].head));
    end
    chk("R5 wm all-ones", 32'(wm), 32'd7);

    // fill: occupancy 3 -> 8, wm 7
    step(1, 8'h1C, 32'h66, 0);
    step(1, 8'h1C, 32'h77, 0);
    step(1, 8'h1C, 32'h88, 0);
    flags("R6 occ6", 1'b1, 1'b0, 1'b0);
    step(1, 8'h1C, 32'h99, 0);
    flags("R6 occ7", 1'b0, 1'b0, 1'b0);
    step(1, 8'h1C, 32'hAA, 0);
    flags("R7 occ8", 1'b0, 1'b1, 1'b0);
    // R3 push while full dropped
    step(1, 8'h1C, 32'hBB, 0);
    flags("R3 full drop", 1'b0, 1'b1, 1'b0);
    chk("R3 head kept", 32'(pop_data), 32'h33);

    begin
      logic [7:0] exp_seq [8] = '{8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA};
      for (int k = 0; k < 8; k++) begin
        chk($sformatf("R2 order %0d", k), 32'(pop_data), 32'(exp_seq[k]));
        step(0, 8'h00, 32'h0, 1);
      end
    end
    flags("R3 drained after 8", 1'b1, 1'b0, 1'b1);

    // R4 pop on empty ignored
    step(0, 8'h00, 32'h0, 1);
    flags("R4 pop empty", 1'b1, 1'b0, 1'b1);
    step(1, 8'h1C, 32'hCC, 0);
    chk("R4 head after refill", 32'(pop_data), 32'hCC);
    flags("R7 one entry", 1'b1, 1'b0, 1'b0);

    // R5 truncation of upper bits
    step(1, 8'h28, 32'h12, 0);
    chk("R5 wm trunc", 32'(wm), 32'd2);
    flags("R6 occ1 wm2", 1'b1, 1'b0, 1'b0);
    // R8 stray write leaves wm alone
    step(1, 8'h24, 32'h5, 0);
    chk("R8 wm kept", 32'(wm), 32'd2);
    chk("R8 head kept", 32'(pop_data), 32'hCC);

    finish_run();
  end
endmodule